// File: doc/BRIEF.md
# Watchdog Clock Guard

This block sits next to a watchdog counter and keeps that counter's count source alive. Software asks for a low-power level: active, level 3 or level 4. The block compares that request with the watchdog's hold bit and its clock choice, which is the auxiliary or the submain tick. It then grants only the deepest level that still keeps the watchdog's tick running. When the watchdog is stopped by its hold bit, any request passes through unchanged.

The block also chooses the tick enable that drives the watchdog counter. Normally it forwards the enable of the selected source. If that source is flagged as failed, the block substitutes the main-clock tick and raises a status flag, so software can see that the watchdog interval has changed. The choice is held in a register, so a change of source takes effect only on a system-clock edge. The tick output therefore never carries a fragment of two sources. Once the failure flag clears, the selected source is used again.

All inputs are synchronous to the system clock. Each tick input is a one-cycle enable pulse.

Top module: `wdg_clk_guard`

## Requirements
- R1: In the clock cycle after a rising edge with `rst_n` low, the outputs are as follows: `lpm_grant` is 0 (active), `tick_src` is 0 (submain) and `fallback_active` is 0.
- R2: Level encoding on `lpm_req` and `lpm_grant` is 0 = active, 1 = level 3, 2 = level 4, and request code 3 counts as level 4. When `wdt_hold` was 1 at an edge, `lpm_grant` after that edge equals the request sampled there, with code 3 reported as 2.
- R3: The watchdog is not held, `wdt_clk_aux` is 1 and `aux_fail` is 0. Under these conditions a level-4 request (2 or 3) is granted as level 3, and requests 0 and 1 are granted unchanged.
- R4: The watchdog is not held and `wdt_clk_aux` is 0 (submain). Under these conditions every request is granted as 0.
- R5: The watchdog is not held and the selected source's failure flag (`aux_fail` if `wdt_clk_aux` is 1, else `sub_fail`) is 1. Under these conditions every request is granted as 0.
- R6: Source encoding on `tick_src` is 0 = submain, 1 = auxiliary, 2 = main. When the selected source is healthy at an edge, `tick_src` after that edge names that source (1 if `wdt_clk_aux` is 1, else 0).
- R7: When the selected source's failure flag is 1 at an edge, `tick_src` becomes 2 after that edge. It returns to the selected source at the first edge at which the flag is 0.
- R8: `fallback_active` is 1 exactly in the cycles in which `tick_src` is 2.
- R9: In every cycle, `wdt_tick` equals the tick input of the source named by `tick_src`: `sub_tick`, `aux_tick` or `main_tick`.
- R10: The failure flag of the source that is not selected has no effect on `tick_src`, `fallback_active` or `lpm_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpm_req | input | 2 | Requested low-power level (0 active, 1 level 3, 2/3 level 4) |
| wdt_hold | input | 1 | Watchdog hold bit; 1 = watchdog stopped |
| wdt_clk_aux | input | 1 | Watchdog clock select; 1 = auxiliary, 0 = submain |
| aux_fail | input | 1 | Auxiliary clock failure flag |
| sub_fail | input | 1 | Submain clock failure flag |
| aux_tick | input | 1 | Auxiliary tick enable |
| sub_tick | input | 1 | Submain tick enable |
| main_tick | input | 1 | Main-clock tick enable |
| lpm_grant | output | 2 | Low-power level the system may enter |
| wdt_tick | output | 1 | Tick enable delivered to the watchdog counter |
| tick_src | output | 2 | Source now driving `wdt_tick` (0 submain, 1 auxiliary, 2 main) |
| fallback_active | output | 1 | 1 while the main-clock substitute is in use |

## Verification
A directed sweep runs every combination of hold bit, clock select, request code and the two failure flags. This sweep separates the pass-through, demotion and denial paths of the grant, and it shows that only the selected source's failure matters. Failure flags are then pulsed high for single cycles and for longer stretches. These pulses show that the switch to the main tick and the return to the selected source each happen on the first following edge. Random ticks and random inputs then run for several thousand cycles. The bench's own model checks every output in every cycle, and this shows that the tick output never mixes in the enable of a source that is not selected.

// File: rtl/wdg_guard_pkg.sv
// Package: shared encodings for the watchdog clock guard.
// Assumes all consumers are synchronous to one system clock.
package wdg_guard_pkg;

    localparam int LVL_W = 2;
    localparam int SRC_W = 2;

    // Low-power level encoding; code 3 is an alias for level 4.
    typedef enum logic [LVL_W-1:0] {
        LVL_ACTIVE = 2'd0,
        LVL_3      = 2'd1,
        LVL_4      = 2'd2,
        LVL_4_ALT  = 2'd3
    } lp_level_e;

    // Tick source encoding.
    typedef enum logic [SRC_W-1:0] {
        SRC_SUB  = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_MAIN = 2'd2,
        SRC_NONE = 2'd3
    } tick_src_e;

    // Fold the alias code onto level 4.
    function automatic lp_level_e norm_level(input lp_level_e lvl);
        return (lvl == LVL_4_ALT) ? LVL_4 : lvl;
    endfunction

endpackage

// File: rtl/wdg_lpm_policy.sv
// Module: wdg_lpm_policy
// Combinational low-power admission policy. Finds the deepest level that
// keeps the watchdog's tick source running. Assumes the caller registers
// the result.
module wdg_lpm_policy
    import wdg_guard_pkg::*;
(
    input  lp_level_e req_lvl,
    input  logic      hold,
    input  logic      use_aux,
    input  logic      sel_failed,
    output lp_level_e allowed_lvl
);

    lp_level_e req_n;

    // Purpose: normalise the request, then cap it against the watchdog clock.
    always_comb begin
        req_n = norm_level(req_lvl);
        if (hold) begin
            allowed_lvl = req_n;
        end else if (sel_failed || !use_aux) begin
            allowed_lvl = LVL_ACTIVE;
        end else if (req_n == LVL_4) begin
            allowed_lvl = LVL_3;
        end else begin
            allowed_lvl = req_n;
        end
    end

endmodule

// File: rtl/wdg_src_select.sv
// Module: wdg_src_select
// Registered choice of the watchdog tick source, with a fallback to the
// main clock while the selected source is flagged as failed. Assumes the
// failure flags are already synchronous to clk.
module wdg_src_select
    import wdg_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      use_aux,
    input  logic      aux_fail,
    input  logic      sub_fail,
    output logic      sel_failed,
    output tick_src_e src_q
);

    tick_src_e src_d;

    // Purpose: pick the failure flag of the selected source and the next source.
    always_comb begin
        sel_failed = use_aux ? aux_fail : sub_fail;
        if (sel_failed) begin
            src_d = SRC_MAIN;
        end else begin
            src_d = use_aux ? SRC_AUX : SRC_SUB;
        end
    end

    // Purpose: switch the source only on a system-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_SUB;
        end else begin
            src_q <= src_d;
        end
    end

    // R7: a failed selected source is replaced by the main tick on the next edge.
    a_r7_fallback_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(use_aux ? aux_fail : sub_fail)) |-> (src_q == SRC_MAIN));

    // R10: a failed unselected auxiliary source does not disturb submain selection.
    a_r10_other_fail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(use_aux) && !$past(sub_fail)) |-> (src_q == SRC_SUB));

endmodule

// File: rtl/wdg_tick_mux.sv
// Module: wdg_tick_mux
// Routes one of the tick enables to the watchdog according to a registered
// source code. Assumes the ticks are one-cycle enables on the same clock.
module wdg_tick_mux
    import wdg_guard_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  tick_src_e        src,
    input  logic [N_SRC-1:0] ticks,
    output logic             tick_out
);

    logic [N_SRC-1:0] hit;

    // One AND term per source; the source code indexes the tick vector.
    for (genvar g = 0; g < N_SRC; g++) begin : g_term
        assign hit[g] = ticks[g] && (src == tick_src_e'(g));
    end

    // Purpose: merge the gated terms into the single tick output.
    always_comb begin
        tick_out = |hit;
    end

endmodule

// File: rtl/wdg_clk_guard.sv
// Module: wdg_clk_guard (top)
// Watchdog clock guard: grants low-power levels that keep the watchdog
// tick alive and feeds the watchdog a tick from its selected source, or
// from the main clock when that source fails. Assumes every input is
// synchronous to clk and that the reset is synchronous and active low.
module wdg_clk_guard
    import wdg_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lpm_req,
    input  logic       wdt_hold,
    input  logic       wdt_clk_aux,
    input  logic       aux_fail,
    input  logic       sub_fail,
    input  logic       aux_tick,
    input  logic       sub_tick,
    input  logic       main_tick,
    output logic [1:0] lpm_grant,
    output logic       wdt_tick,
    output logic [1:0] tick_src,
    output logic       fallback_active
);

    localparam int N_SRC = 3;

    lp_level_e        allowed;
    lp_level_e        grant_q;
    logic             sel_failed;
    tick_src_e        src_q;
    logic [N_SRC-1:0] tick_vec;

    wdg_lpm_policy u_policy (
        .req_lvl     (lp_level_e'(lpm_req)),
        .hold        (wdt_hold),
        .use_aux     (wdt_clk_aux),
        .sel_failed  (sel_failed),
        .allowed_lvl (allowed)
    );

    wdg_src_select u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_aux    (wdt_clk_aux),
        .aux_fail   (aux_fail),
        .sub_fail   (sub_fail),
        .sel_failed (sel_failed),
        .src_q      (src_q)
    );

    // Tick vector indexed by source code: 0 submain, 1 auxiliary, 2 main.
    assign tick_vec = {main_tick, aux_tick, sub_tick};

    wdg_tick_mux #(.N_SRC(N_SRC)) u_mux (
        .src      (src_q),
        .ticks    (tick_vec),
        .tick_out (wdt_tick)
    );

    // Purpose: register the granted level so it changes only on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= LVL_ACTIVE;
        end else begin
            grant_q <= allowed;
        end
    end

    // Purpose: drive the output ports from the registered state.
    always_comb begin
        lpm_grant       = grant_q;
        tick_src        = src_q;
        fallback_active = (src_q == SRC_MAIN);
    end

    // R2: with hold set, the request passes through with code 3 folded onto 2.
    a_r2_hold_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wdt_hold)) |->
        (lpm_grant == (($past(lpm_req) == 2'd3) ? 2'd2 : $past(lpm_req))));

    // R3: an unheld watchdog never allows level 4.
    a_r3_no_level4_unheld: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wdt_hold)) |-> (lpm_grant != 2'd2));

    // R4: an unheld watchdog on the submain source keeps the system active.
    a_r4_submain_active: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wdt_hold) && !$past(wdt_clk_aux)) |-> (lpm_grant == 2'd0));

    // R5: an unheld watchdog whose source failed keeps the system active.
    a_r5_failed_active: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wdt_hold) && $past(wdt_clk_aux) && $past(aux_fail))
        |-> (lpm_grant == 2'd0));

    // R9: while the source is main, the submain and auxiliary ticks do not reach the output.
    a_r9_no_foreign_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_src == 2'd2 && !main_tick) |-> !wdt_tick);

endmodule

// File: tb/wdg_clk_guard_tb.sv
`timescale 1ns/100ps
module wdg_clk_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] lpm_req;
    logic       wdt_hold, wdt_clk_aux, aux_fail, sub_fail;
    logic       aux_tick, sub_tick, main_tick;
    logic [1:0] lpm_grant, tick_src;
    logic       wdt_tick, fallback_active;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // Reference model state
    int exp_grant = 0;
    int exp_src   = 0;
    string grant_tag = "R1";
    string src_tag   = "R1";

    always #2.5 clk = ~clk;

    wdg_clk_guard u_dut (
        .clk(clk), .rst_n(rst_n), .lpm_req(lpm_req), .wdt_hold(wdt_hold),
        .wdt_clk_aux(wdt_clk_aux), .aux_fail(aux_fail), .sub_fail(sub_fail),
        .aux_tick(aux_tick), .sub_tick(sub_tick), .main_tick(main_tick),
        .lpm_grant(lpm_grant), .wdt_tick(wdt_tick), .tick_src(tick_src),
        .fallback_active(fallback_active)
    );

    // Behavioural model: update on every rising edge from the sampled inputs.
    always @(posedge clk) begin
        int req;
        bit failed, other_failed;
        cycles++;
        if (!rst_n) begin
            exp_grant = 0; exp_src = 0; grant_tag = "R1"; src_tag = "R1";
        end else begin
            req = (lpm_req == 2'd3) ? 2 : int'(lpm_req);
            failed = wdt_clk_aux ? aux_fail : sub_fail;
            other_failed = wdt_clk_aux ? sub_fail : aux_fail;
            if (wdt_hold) begin
                exp_grant = req; grant_tag = "R2";
            end else if (failed) begin
                exp_grant = 0; grant_tag = "R5";
            end else if (!wdt_clk_aux) begin
                exp_grant = 0; grant_tag = "R4";
            end else begin
                exp_grant = (req == 2) ? 1 : req; grant_tag = other_failed ? "R10" : "R3";
            end
            if (failed) begin
                exp_src = 2; src_tag = "R7";
            end else begin
                exp_src = wdt_clk_aux ? 1 : 0;
                src_tag = other_failed ? "R10" : "R6";
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Compare every output against the model (R8 fallback, R9 tick routing).
    task automatic compare_all();
        int exp_tick;
        exp_tick = (exp_src == 0) ? int'(sub_tick) : (exp_src == 1) ? int'(aux_tick) : int'(main_tick);
        check(grant_tag, "lpm_grant", int'(lpm_grant), exp_grant);
        check(src_tag, "tick_src", int'(tick_src), exp_src);
        check("R8", "fallback_active", int'(fallback_active), (exp_src == 2) ? 1 : 0);
        check("R9", "wdt_tick", int'(wdt_tick), exp_tick);
    endtask

    // Drive one cycle of inputs on the falling edge, then compare.
    task automatic step(input logic [1:0] rq, input logic h, input logic ax,
                        input logic af, input logic sf, input logic [2:0] tk);
        @(negedge clk);
        lpm_req = rq; wdt_hold = h; wdt_clk_aux = ax; aux_fail = af; sub_fail = sf;
        {main_tick, aux_tick, sub_tick} = tk;
        #1;
        compare_all();
    endtask

    initial begin
        rst_n = 1'b0; lpm_req = 2'd2; wdt_hold = 1'b0; wdt_clk_aux = 1'b1;
        aux_fail = 1'b1; sub_fail = 1'b1; aux_tick = 1'b1; sub_tick = 1'b1; main_tick = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state while inputs are busy
        check("R1", "lpm_grant reset", int'(lpm_grant), 0);
        check("R1", "tick_src reset", int'(tick_src), 0);
        check("R1", "fallback reset", int'(fallback_active), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2..R5, R10: exhaustive sweep of the policy inputs, two cycles each
        for (int h = 0; h < 2; h++)
            for (int ax = 0; ax < 2; ax++)
                for (int af = 0; af < 2; af++)
                    for (int sf = 0; sf < 2; sf++)
                        for (int rq = 0; rq < 4; rq++)
                            repeat (2) step(rq[1:0], h[0], ax[0], af[0], sf[0], 3'b111);

        // R7: single-cycle failure pulse on the auxiliary source, then recovery
        step(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b010);
        step(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b010);
        step(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b100);
        step(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b110);
        // R7: long submain failure, then recovery
        repeat (5) step(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'b101);
        step(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101);
        step(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001);
        // R10: unselected source fails while the selected one is healthy
        repeat (3) step(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 3'b011);
        repeat (3) step(2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'b011);

        // R6, R8, R9: random inputs and ticks
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[1:0], r[2], r[3], (r[7:4] == 4'd0), (r[11:8] == 4'd0), r[14:12]);
        end

        // R1: synchronous reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0; wdt_hold = 1'b1; lpm_req = 2'd2; aux_fail = 1'b1;
        @(negedge clk);
        compare_all();
        check("R1", "fallback after mid reset", int'(fallback_active), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule